// File: doc/BRIEF.md
# Periodic DRAM Refresh Requester

This block keeps dynamic memory alive by asking for the bus at a fixed rate and running one refresh cycle per request. A down-counter running on the processor clock measures the refresh interval. It is loaded from a programmable interval register. Each time it runs out it reloads at once and flags a refresh. The block then raises a bus request and holds it until the arbiter grants the bus. After the grant it drives one refresh cycle of fixed length. The address of that cycle is a programmable base in the upper bits with a row counter in the lower bits, and the row counter advances after every completed cycle.

Software sets the block up through four register slots. Slot 0 is the base, slot 1 is the interval and slot 2 is the control word. Slot 3 is a read-only view of the current refresh address. Software picks the interval so that one refresh per row fits inside the memory's retention time. That interval is the retention period in microseconds times the clock in MHz, divided by the row count raised by a few percent of margin for bus latency. At low clock rates refresh traffic can fill nearly all of the bus. For that reason an expiry that arrives while a refresh is still waiting is kept as a pending flag and is not dropped.

The request/grant pair works like a valid/ready handshake. `bus_req` is the valid side and stays high until `bus_gnt` is seen high at a clock edge. The block does not withdraw a raised request. A grant that arrives while no request is raised has no effect.

Top module: `rfsh_ctrl`

## Requirements
- R1: Synchronous reset clears enable, the row counter, the pending flag and all registers. After reset `bus_req` and `rfsh_cyc` are low, and every slot reads 0.
- R2: Writes take effect at the clock edge where `wr_en` is high. Slot 0 holds the base (low BASE_W bits of the data), slot 1 holds the interval (low IVL_W bits) and slot 2 bit 0 holds enable. `rd_data` shows the slot named by `rd_sel` combinationally.
- R3: Slot 3 reads `{base, row}`, zero-extended. A write to slot 3 changes nothing.
- R4: Writing slot 2 with bit 0 set loads the counter from the interval. Writing slot 2 with bit 0 clear stops the counter, clears the pending flag and prevents new requests, while a request already raised still completes. No expiry is taken at the edge of a slot 2 write.
- R5: With interval N ≥ 1, `bus_req` rises N cycles after the enabling edge. After that the counter expires every N cycles no matter how long grants take, because it reloads at expiry. An interval of 0 behaves as 1.
- R6: `bus_req` stays high until `bus_gnt` is high at an edge. From the next cycle `rfsh_cyc` is high for CYC_LEN cycles. `bus_req` falls together with `rfsh_cyc` unless a further refresh is due.
- R7: `rfsh_addr` is always `{base, row}`. The row increments by one at the end of each refresh cycle and wraps from 2^ROW_W−1 to 0.
- R8: An expiry while a request is outstanding sets a single pending flag. When the cycle ends, a set flag (or an expiry in that same cycle) keeps `bus_req` high for the next refresh. Further expiries while the flag is already set are merged into it.
- R9: Only one refresh is outstanding at a time, and `rfsh_cyc` is never high without `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | processor clock |
| rst | input | 1 | synchronous reset, active high |
| wr_en | input | 1 | register write strobe |
| wr_sel | input | 2 | slot written: 0 base, 1 interval, 2 control, 3 read-only |
| wr_data | input | DATA_W | write data |
| rd_sel | input | 2 | slot read |
| rd_data | output | DATA_W | contents of the selected slot |
| bus_req | output | 1 | refresh bus request (valid side) |
| bus_gnt | input | 1 | bus grant (ready side) |
| rfsh_cyc | output | 1 | refresh cycle in progress |
| rfsh_addr | output | BASE_W+ROW_W | refresh address, base above row |

## Verification
Register writes show on `rd_data` in the cycle after their edge. `bus_req` rises N edges after an enabling write. `rfsh_cyc` rises one edge after a sampled grant, lasts CYC_LEN cycles, and the row count is updated at the same edge where it falls. The bench drives inputs on the falling edge and keeps a cycle model that it advances on each rising edge. It compares the outputs with that model shortly after the falling edge, so every result is read exactly one edge after the cause named above. The directed checks count the same edges with explicit waits.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_CYC} sq_state_t;
  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_IVL  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_ADDR = 2'd3;
endpackage

// File: rtl/rfsh_regs.sv
module rfsh_regs
  import rfsh_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BASE_W = 8,
  parameter int IVL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BASE_W-1:0] base,
  output logic [IVL_W-1:0]  ivl,
  output logic              en,
  output logic              ctrl_wr,
  output logic              ena_set,
  output logic              ena_clr
);
  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
  assign ena_set = ctrl_wr && wr_data[0];
  assign ena_clr = ctrl_wr && !wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      ivl  <= '0;
      en   <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_BASE: base <= wr_data[BASE_W-1:0];
        SEL_IVL:  ivl  <= wr_data[IVL_W-1:0];
        SEL_CTRL: en   <= wr_data[0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic             hold,
  input  logic [IVL_W-1:0] ivl,
  output logic             expire
);
  localparam logic [IVL_W-1:0] ONE = IVL_W'(1);
  logic [IVL_W-1:0] cnt;

  // reload happens at expiry, so bus latency never stretches the period
  assign expire = en && !hold && (cnt <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= ivl;
    end else if (en) begin
      if (cnt <= ONE) cnt <= ivl;
      else            cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int ROW_W   = 8,
  parameter int CYC_LEN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expire,
  input  logic             drop_pend,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             rfsh_cyc,
  output logic [ROW_W-1:0] row
);
  localparam int CC_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [CC_W-1:0] CC_LAST = CC_W'(CYC_LEN - 1);

  sq_state_t       st;
  logic            pend;
  logic [CC_W-1:0] ccnt;
  logic            done;

  assign done     = (st == SQ_CYC) && (ccnt == CC_LAST);
  assign bus_req  = (st != SQ_IDLE);
  assign rfsh_cyc = (st == SQ_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SQ_IDLE;
      pend <= 1'b0;
      ccnt <= '0;
      row  <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (expire) st <= SQ_REQ;
        SQ_REQ: begin
          if (bus_gnt) begin
            st   <= SQ_CYC;
            ccnt <= '0;
          end
        end
        SQ_CYC: begin
          if (done) begin
            row <= row + ROW_W'(1);
            st  <= ((pend && !drop_pend) || expire) ? SQ_REQ : SQ_IDLE;
          end else begin
            ccnt <= ccnt + CC_W'(1);
          end
        end
        default: st <= SQ_IDLE;
      endcase

      if (drop_pend)                      pend <= 1'b0;
      else if (done)                      pend <= pend && expire;
      else if (expire && st != SQ_IDLE)   pend <= 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BASE_W  = 8,
  parameter int ROW_W   = 8,
  parameter int IVL_W   = 16,
  parameter int CYC_LEN = 3,
  localparam int ADDR_W = BASE_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              rfsh_cyc,
  output logic [ADDR_W-1:0] rfsh_addr
);
  logic [BASE_W-1:0] base;
  logic [IVL_W-1:0]  ivl;
  logic [ROW_W-1:0]  row;
  logic en, ctrl_wr, ena_set, ena_clr, expire;

  rfsh_regs #(.DATA_W(DATA_W), .BASE_W(BASE_W), .IVL_W(IVL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .base(base), .ivl(ivl), .en(en), .ctrl_wr(ctrl_wr),
    .ena_set(ena_set), .ena_clr(ena_clr)
  );

  rfsh_timer #(.IVL_W(IVL_W)) u_timer (
    .clk(clk), .rst(rst), .en(en), .load(ena_set), .hold(ctrl_wr),
    .ivl(ivl), .expire(expire)
  );

  rfsh_seq #(.ROW_W(ROW_W), .CYC_LEN(CYC_LEN)) u_seq (
    .clk(clk), .rst(rst), .expire(expire), .drop_pend(ena_clr),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .rfsh_cyc(rfsh_cyc), .row(row)
  );

  assign rfsh_addr = {base, row};

  always_comb begin
    case (rd_sel)
      SEL_BASE: rd_data = DATA_W'(base);
      SEL_IVL:  rd_data = DATA_W'(ivl);
      SEL_CTRL: rd_data = DATA_W'(en);
      default:  rd_data = DATA_W'(rfsh_addr);
    endcase
  end
endmodule

// File: rtl/rfsh_ctrl_chk.sv
module rfsh_ctrl_chk #(
  parameter int ROW_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             rfsh_cyc,
  input logic [ROW_W-1:0] row
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_req && !rfsh_cyc));

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !rfsh_cyc && !bus_gnt) |=> bus_req);

  // R6
  cyc_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rfsh_cyc) |-> ($past(bus_gnt) && $past(bus_req)));

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req) |-> $past(rfsh_cyc));

  // R9
  cyc_owned_chk: assert property (@(posedge clk) disable iff (rst)
    rfsh_cyc |-> bus_req);

  // R7
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rfsh_cyc) |-> (row == ROW_W'($past(row) + ROW_W'(1))));
endmodule

bind rfsh_ctrl rfsh_ctrl_chk #(.ROW_W(ROW_W)) i_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .rfsh_cyc(rfsh_cyc), .row(rfsh_addr[ROW_W-1:0])
);

// File: tb/test_rfsh_ctrl.sv
module test_rfsh_ctrl;
  localparam int DATA_W = 16, BASE_W = 8, ROW_W = 8, IVL_W = 16, CYC_LEN = 3;
  localparam int ADDR_W = BASE_W + ROW_W;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, bus_gnt = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = 2'd3;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic bus_req, rfsh_cyc;
  logic [ADDR_W-1:0] rfsh_addr;

  int total = 0, bad = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  rfsh_ctrl i_rfsh_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .rfsh_cyc(rfsh_cyc), .rfsh_addr(rfsh_addr)
  );

  // cycle model built from the requirements
  logic [BASE_W-1:0] m_base;
  logic [IVL_W-1:0]  m_ivl, m_cnt;
  logic [ROW_W-1:0]  m_row;
  logic m_en, m_pend;
  int m_st, m_cc;

  always @(posedge clk) begin
    logic cw, ex, dn, dp;
    if (rst) begin
      m_base <= '0; m_ivl <= '0; m_cnt <= '0; m_row <= '0;
      m_en <= 0; m_pend <= 0; m_st <= 0; m_cc <= 0;
    end else begin
      cw = wr_en && wr_sel == 2'd2;
      dp = cw && !wr_data[0];
      ex = m_en && !cw && (m_cnt <= 1);
      dn = (m_st == 2) && (m_cc == CYC_LEN - 1);
      if (cw && wr_data[0]) m_cnt <= m_ivl;
      else if (m_en) m_cnt <= (m_cnt <= 1) ? m_ivl : m_cnt - 1;
      if (wr_en && wr_sel == 2'd0) m_base <= wr_data[BASE_W-1:0];
      if (wr_en && wr_sel == 2'd1) m_ivl <= wr_data[IVL_W-1:0];
      if (cw) m_en <= wr_data[0];
      if (m_st == 0 && ex) m_st <= 1;
      else if (m_st == 1 && bus_gnt) begin m_st <= 2; m_cc <= 0; end
      else if (m_st == 2) begin
        if (dn) begin
          m_row <= m_row + 1'b1;
          m_st <= ((m_pend && !dp) || ex) ? 1 : 0;
        end else m_cc <= m_cc + 1;
      end
      if (dp) m_pend <= 0;
      else if (dn) m_pend <= m_pend && ex;
      else if (ex && m_st != 0) m_pend <= 1;
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] s);
    case (s)
      2'd0: return 32'(m_base);
      2'd1: return 32'(m_ivl);
      2'd2: return 32'(m_en);
      default: return 32'({m_base, m_row});
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (cmp_on && !rst) begin
      chk("R6 req", 32'(bus_req), 32'(m_st != 0));
      chk("R6 cyc", 32'(rfsh_cyc), 32'(m_st == 2));
      chk("R7 addr", 32'(rfsh_addr), 32'({m_base, m_row}));
      chk("R2 rd", 32'(rd_data), m_read(rd_sel));
    end
  end

  int falls = 0;
  logic prev_cyc = 0;
  always @(negedge clk) begin
    if (prev_cyc && !rfsh_cyc) falls++;
    prev_cyc <= rfsh_cyc;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] s, input logic [31:0] exp);
    rd_sel = s; #1;
    chk(tag, 32'(rd_data), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f0;
    void'($urandom(32'd2024));
    tick(3); rst = 0; cmp_on = 1;
    tick(1);
    // R1 reset state
    chk("R1 req", 32'(bus_req), 0);
    chk("R1 cyc", 32'(rfsh_cyc), 0);
    rd_chk("R1 addr", 2'd3, 0);
    rd_chk("R1 ctrl", 2'd2, 0);
    // R2 register readback
    wr(2'd0, 16'h005A);
    wr(2'd1, 16'd6);
    rd_chk("R2 base", 2'd0, 32'h5A);
    rd_chk("R2 ivl", 2'd1, 6);
    rd_sel = 2'd3;
    // R4/R5 enable reloads, request after N cycles
    wr(2'd2, 16'h1);
    tick(5); chk("R5 early", 32'(bus_req), 0);
    tick(1); chk("R5 rise", 32'(bus_req), 1);
    // R6 request held without grant
    tick(10);
    chk("R6 hold", 32'(bus_req), 1);
    chk("R6 nocyc", 32'(rfsh_cyc), 0);
    bus_gnt = 1; tick(1); bus_gnt = 0;
    chk("R6 cyc on", 32'(rfsh_cyc), 1);
    chk("R7 addr0", 32'(rfsh_addr), 32'h5A00);
    tick(2); chk("R6 cyc len", 32'(rfsh_cyc), 1);
    tick(1); chk("R6 cyc off", 32'(rfsh_cyc), 0);
    chk("R8 pending rereq", 32'(bus_req), 1);
    rd_chk("R7 row inc", 2'd3, 32'h5A01);
    // R4 disable: in-flight completes, nothing new
    wr(2'd2, 16'h0);
    bus_gnt = 1; tick(1); bus_gnt = 0;
    tick(3); chk("R4 done", 32'(bus_req), 0);
    tick(20); chk("R4 stopped", 32'(bus_req), 0);
    rd_chk("R4 row", 2'd3, 32'h5A02);
    // R3 slot 3 is read-only
    wr(2'd3, 16'hFFFF);
    rd_chk("R3 ro", 2'd3, 32'h5A02);
    rd_chk("R3 base kept", 2'd0, 32'h5A);
    // R5 interval 0 acts as 1, R7 wrap, R9 back-to-back
    rd_sel = 2'd3;
    wr(2'd1, 16'd0);
    f0 = falls;
    bus_gnt = 1;
    wr(2'd2, 16'h1);
    tick(1200);
    bus_gnt = 0;
    wr(2'd2, 16'h0);
    bus_gnt = 1; tick(8); bus_gnt = 0; tick(2);
    chk("R7 wrapped", 32'((falls - f0) > 254), 1);
    rd_chk("R7 wrap row", 2'd3, 32'({8'h5A, 8'((2 + falls - f0) % 256)}));
    // R8 merged expiries: one pending only
    wr(2'd1, 16'd4);
    wr(2'd2, 16'h1);
    tick(30);
    bus_gnt = 1; tick(1); bus_gnt = 0;
    tick(3); chk("R8 one more", 32'(bus_req), 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      bus_gnt = ($urandom % 3) == 0;
      rd_sel = 2'($urandom);
      wr_en = 0;
      if (($urandom % 150) == 0) begin
        wr_en = 1;
        wr_sel = 2'($urandom);
        wr_data = 16'($urandom);
        if (wr_sel == 2'd1) wr_data = wr_data & 16'h000F;
        if (wr_sel == 2'd2 && ($urandom % 4) != 0) wr_data[0] = 1'b1;
      end
    end
    @(negedge clk); wr_en = 0;
    tick(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule